// File: doc/BRIEF.md
# Parallel Display Command/Data Bridge

The bridge sits between a 32-bit register bus and a 16-bit parallel bus shared by two external display chips, each with its own chip-select. Writes to dedicated ports become command, parameter or pixel-data beats on the parallel bus. Writes to the read and status ports fetch one 16-bit word from a chip into a receive buffer. A pixel down-counter paces frame transfers. A qualified start trigger sets a busy flag and pulses `fetch_start_o` toward an external fetch engine. When the counter runs out, busy drops and `frame_done_o` pulses.

The register bus is a valid/ready channel. The master raises `reg_valid` with `reg_write`, `reg_addr` and `reg_wdata`, and holds them unchanged until it samples `reg_ready` high. The access takes effect at that clock edge. A read returns `reg_rdata` in the same cycle that `reg_ready` is high. Register-only accesses finish in the cycle they are presented. An access that drives the parallel bus is back-pressured until the last beat has been acknowledged. Each parallel beat holds the chip-select(s), the command/data line (`pb_dc_o`, 0 = command, 1 = data) and one strobe until every selected chip raises its `pb_ready_i` bit. Per-chip timing, format and sync-width fields are stored for software but do not shape the bus cycles.

Top module: `pdisp_bridge`

Word addresses on `reg_addr`:
- 0 system config (bit 1 soft reset)
- 1 system status
- 2 control
- 3 pixel count
- 4 line skip
- 5 command port
- 6 parameter port
- 7 data port
- 8 read port
- 9 status port
- 10–15 chip 0 timing bank (config, on/off time, cycle time, three data-cycle words)
- 16–21 chip 1 timing bank, in the same order
- 22 vertical sync width
- 23 horizontal sync width

Control bits:
- bit 0 enable
- bit 1 bypass
- bit 2 selects chip 0
- bit 3 selects chip 1
- bit 4 start trigger, which is not stored

## Requirements
- R1: After reset, control reads 0x2, both chip config words read 0x00310000, system status reads 0x1, and every other register (pixel count, timing, line skip, sync widths, system config) reads 0. `fetch_start_o` and `frame_done_o` are low.
- R2: A control write stores bits 3:0 only, so bit 4 and above always read back as 0.
- R3: A command-port write drives one write beat with `pb_dc_o`=0, `pb_cs_o`=control[3:2] and `pb_wdata_o`=wdata[15:0]. The beat holds its chip-select, line and data until all selected chips are ready. `reg_ready` rises only in the cycle where that beat is acknowledged, so with a chip needing L ready-cycles the access lasts L+2 cycles.
- R4: A parameter-port write drives the same single beat with `pb_dc_o`=1.
- R5: A data-port write drives two write beats with `pb_dc_o`=1 to every selected chip: wdata[15:0] first, then wdata[31:16]. The strobe drops for at least one cycle between the beats.
- R6: A read-port write performs one read beat with `pb_dc_o`=1; a status-port write does the same with `pb_dc_o`=0. The beat uses chip 0 (`pb_cs_o`=01) when control[2] is set, otherwise chip 1 (`pb_cs_o`=10). The word on `pb_rdata_i` is stored in the receive buffer, and both ports read back that buffer in bits 15:0.
- R7: With control[3:2]=0, command, parameter, data, read and status writes drive no strobe and complete in the cycle they are presented.
- R8: Every data, read or status write decrements a nonzero pixel count by one. A count of 0 stays at 0.
- R9: A control write with bit 4 set starts a frame if all of the following hold:
  - the written enable bit is 1;
  - the written bypass bit is 0;
  - `ctl_mode_i` is high;
  - the block is not busy;
  - bits 3:2 of the two chip config words share no set bit.
  A start sets busy (system status bit 8) and pulses `fetch_start_o` for one cycle.
- R10: A start trigger that fails any condition of R9 leaves busy and `fetch_start_o` unchanged.
- R11: When a decrement brings the count to 0 while busy, busy clears and `frame_done_o` is high for exactly the following cycle.
- R12: Writes keep these masks:
  - config words: 0x003F1FFF
  - on/off time: 0x3FFFFFFF
  - cycle time: 0x0FFFFFFF
  - data-cycle words: 0x0F1F0F1F
  - line skip: 11 bits
  - sync widths: 16 bits
  - pixel count: full width
- R13: A system-config write with bit 1 set returns every register of R1 to its reset value and clears busy without a `frame_done_o` pulse. The system-config register then holds the written value ANDed with 0x19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_ready on a read |
| ctl_mode_i | input | 1 | Display controller is in bridge mode |
| pb_cs_o | output | 2 | Chip-selects, bit 0 = chip 0 |
| pb_dc_o | output | 1 | 0 = command/status, 1 = data/parameter |
| pb_wr_o | output | 1 | Write strobe |
| pb_rd_o | output | 1 | Read strobe |
| pb_wdata_o | output | 16 | Parallel write data |
| pb_rdata_i | input | 16 | Parallel read data |
| pb_ready_i | input | 2 | Per-chip beat acknowledge |
| fetch_start_o | output | 1 | One-cycle frame start pulse |
| frame_done_o | output | 1 | One-cycle frame completion pulse |

## Verification
A beat sequencer stuck in the wrong state shows at once on the parallel pins: a strobe with no chip-select, both strobes together, data changing before ready, or a missing gap between data halves. It also shows as `reg_ready` arriving earlier or later than L+2 cycles. A wrong pixel count or busy bit stays hidden until the next status read or the last data access, where `frame_done_o` either fails to appear or appears one access early. A mis-decoded register offset or mask is exposed by the very next read-back of that word.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int REG_AW = 5;
  localparam int RW     = 32;
  localparam int PB_W   = 16;
  localparam int NCHIP  = 2;

  // word addresses; bank offsets follow the order cfg, on/off, cycle, dcy0..2
  localparam logic [REG_AW-1:0] A_SYSCFG  = 5'd0;
  localparam logic [REG_AW-1:0] A_SYSSTAT = 5'd1;
  localparam logic [REG_AW-1:0] A_CTRL    = 5'd2;
  localparam logic [REG_AW-1:0] A_PIXCNT  = 5'd3;
  localparam logic [REG_AW-1:0] A_SKIP    = 5'd4;
  localparam logic [REG_AW-1:0] A_CMD     = 5'd5;
  localparam logic [REG_AW-1:0] A_PARAM   = 5'd6;
  localparam logic [REG_AW-1:0] A_DATA    = 5'd7;
  localparam logic [REG_AW-1:0] A_READ    = 5'd8;
  localparam logic [REG_AW-1:0] A_STAT    = 5'd9;
  localparam int                BANK_BASE = 10;
  localparam int                BANK_REGS = 6;
  localparam logic [REG_AW-1:0] A_VSW     = 5'd22;
  localparam logic [REG_AW-1:0] A_HSW     = 5'd23;

  localparam logic [RW-1:0] CFG_RST    = 32'h0031_0000;
  localparam logic [RW-1:0] CFG_MASK   = 32'h003F_1FFF;
  localparam logic [RW-1:0] ONOFF_MASK = 32'h3FFF_FFFF;
  localparam logic [RW-1:0] CYC_MASK   = 32'h0FFF_FFFF;
  localparam logic [RW-1:0] DCY_MASK   = 32'h0F1F_0F1F;
  localparam logic [4:0]    SYS_MASK   = 5'h19;
  localparam logic [3:0]    CTRL_RST   = 4'h2;

  typedef enum logic [1:0] {OP_WR1, OP_WR2, OP_RD} beat_op_e;
endpackage

// File: rtl/pdb_timing_bank.sv
module pdb_timing_bank
  import pdb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] rdata_o,
  output logic [1:0]    csel_o
);
  localparam int NDCY = BANK_REGS - 3;

  logic [RW-1:0] cfg_q, onoff_q, cyc_q;
  logic [RW-1:0] dcy_q [NDCY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      onoff_q <= '0;
      cyc_q   <= '0;
      for (int i = 0; i < NDCY; i++) dcy_q[i] <= '0;
    end else if (clr_i) begin
      cfg_q   <= CFG_RST;
      onoff_q <= '0;
      cyc_q   <= '0;
      for (int i = 0; i < NDCY; i++) dcy_q[i] <= '0;
    end else if (we_i) begin
      case (sel_i)
        3'd0:    cfg_q   <= wdata_i & CFG_MASK;
        3'd1:    onoff_q <= wdata_i & ONOFF_MASK;
        3'd2:    cyc_q   <= wdata_i & CYC_MASK;
        default: begin
          for (int i = 0; i < NDCY; i++)
            if (sel_i == 3'(i + 3)) dcy_q[i] <= wdata_i & DCY_MASK;
        end
      endcase
    end
  end

  always_comb begin
    case (sel_i)
      3'd0:    rdata_o = cfg_q;
      3'd1:    rdata_o = onoff_q;
      3'd2:    rdata_o = cyc_q;
      default: begin
        rdata_o = '0;
        for (int i = 0; i < NDCY; i++)
          if (sel_i == 3'(i + 3)) rdata_o = dcy_q[i];
      end
    endcase
  end

  assign csel_o = cfg_q[3:2];
endmodule

// File: rtl/pdb_beat_engine.sv
module pdb_beat_engine
  import pdb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  beat_op_e         op_i,
  input  logic             dc_i,
  input  logic [NCHIP-1:0] cs_i,
  input  logic [2*PB_W-1:0] wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PB_W-1:0]  rword_o,
  output logic [NCHIP-1:0] pb_cs,
  output logic             pb_dc,
  output logic             pb_wr,
  output logic             pb_rd,
  output logic [PB_W-1:0]  pb_wdata,
  input  logic [PB_W-1:0]  pb_rdata,
  input  logic [NCHIP-1:0] pb_ready
);
  typedef enum logic [1:0] {E_IDLE, E_ACT, E_GAP} eng_st_e;
  eng_st_e        st_q;
  logic           second_q;
  logic [PB_W-1:0] hi_q;
  logic           all_ready;

  assign all_ready = &(pb_ready | ~pb_cs);
  assign done_o    = (st_q == E_ACT) && all_ready && !second_q;
  assign busy_o    = (st_q != E_IDLE);
  assign rword_o   = pb_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= E_IDLE;
      second_q <= 1'b0;
      hi_q     <= '0;
      pb_cs    <= '0;
      pb_dc    <= 1'b0;
      pb_wr    <= 1'b0;
      pb_rd    <= 1'b0;
      pb_wdata <= '0;
    end else begin
      case (st_q)
        E_IDLE: if (go_i) begin
          st_q     <= E_ACT;
          pb_cs    <= cs_i;
          pb_dc    <= dc_i;
          pb_wr    <= (op_i != OP_RD);
          pb_rd    <= (op_i == OP_RD);
          pb_wdata <= wdata_i[PB_W-1:0];
          hi_q     <= wdata_i[2*PB_W-1:PB_W];
          second_q <= (op_i == OP_WR2);
        end
        E_ACT: if (all_ready) begin
          pb_wr <= 1'b0;
          pb_rd <= 1'b0;
          if (second_q) begin
            st_q     <= E_GAP;
            second_q <= 1'b0;
            pb_wdata <= hi_q;
          end else begin
            st_q  <= E_IDLE;
            pb_cs <= '0;
          end
        end
        E_GAP: begin
          pb_wr <= 1'b1;
          st_q  <= E_ACT;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  p_rw_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pb_wr && pb_rd));
  p_read_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pb_rd |-> ($countones(pb_cs) == 1));
  p_strobe_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_wr || pb_rd) |-> (pb_cs != '0));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_wr && !all_ready) |=> (pb_wr && $stable(pb_wdata) && $stable(pb_cs) && $stable(pb_dc)));
endmodule

// File: rtl/pdb_frame_ctl.sv
module pdb_frame_ctl #(
  parameter int PIX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             cnt_we_i,
  input  logic [PIX_W-1:0] cnt_wdata_i,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic             en_i,
  input  logic             byp_i,
  input  logic             mode_ok_i,
  input  logic             clash_i,
  output logic [PIX_W-1:0] count_o,
  output logic             busy_o,
  output logic             fetch_start_o,
  output logic             frame_done_o
);
  logic start_go;
  assign start_go = trig_i && en_i && !byp_i && mode_ok_i && !clash_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o       <= '0;
      busy_o        <= 1'b0;
      fetch_start_o <= 1'b0;
      frame_done_o  <= 1'b0;
    end else if (clr_i) begin
      count_o       <= '0;
      busy_o        <= 1'b0;
      fetch_start_o <= 1'b0;
      frame_done_o  <= 1'b0;
    end else begin
      fetch_start_o <= start_go;
      frame_done_o  <= 1'b0;
      if (start_go) busy_o <= 1'b1;
      if (cnt_we_i) begin
        count_o <= cnt_wdata_i;
      end else if (tick_i && (count_o != '0)) begin
        count_o <= count_o - 1'b1;
        if ((count_o == PIX_W'(1)) && busy_o) begin
          busy_o       <= 1'b0;
          frame_done_o <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (!busy_o && $past(busy_o) && (count_o == '0)));
  p_start_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start_o |-> (busy_o && !$past(busy_o)));
endmodule

// File: rtl/pdisp_bridge.sv
module pdisp_bridge
  import pdb_pkg::*;
#(
  parameter int PIX_W  = 32,
  parameter int LINE_W = 11,
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic              ctl_mode_i,
  output logic [NCHIP-1:0]  pb_cs_o,
  output logic              pb_dc_o,
  output logic              pb_wr_o,
  output logic              pb_rd_o,
  output logic [PB_W-1:0]   pb_wdata_o,
  input  logic [PB_W-1:0]   pb_rdata_i,
  input  logic [NCHIP-1:0]  pb_ready_i,
  output logic              fetch_start_o,
  output logic              frame_done_o
);
  logic [3:0]        ctrl_q;
  logic [4:0]        sys_q;
  logic [LINE_W-1:0] skip_q;
  logic [SYNC_W-1:0] vsw_q, hsw_q;
  logic [PB_W-1:0]   rx_q;

  logic hit_sys, hit_ctrl, hit_pix, hit_skip, hit_cmd, hit_param, hit_data;
  logic hit_read, hit_stat, hit_vsw, hit_hsw, rd_kind, bus_kind;
  logic [1:0] chip_sel;
  logic need_bus, eng_go, eng_busy, eng_done, commit, soft_clr, tick, clash;
  beat_op_e          eng_op;
  logic              eng_dc;
  logic [NCHIP-1:0]  eng_cs;
  logic [PB_W-1:0]   eng_rword;
  logic [PIX_W-1:0]  pix_count;
  logic              busy;

  assign hit_sys   = (reg_addr == A_SYSCFG);
  assign hit_ctrl  = (reg_addr == A_CTRL);
  assign hit_pix   = (reg_addr == A_PIXCNT);
  assign hit_skip  = (reg_addr == A_SKIP);
  assign hit_cmd   = (reg_addr == A_CMD);
  assign hit_param = (reg_addr == A_PARAM);
  assign hit_data  = (reg_addr == A_DATA);
  assign hit_read  = (reg_addr == A_READ);
  assign hit_stat  = (reg_addr == A_STAT);
  assign hit_vsw   = (reg_addr == A_VSW);
  assign hit_hsw   = (reg_addr == A_HSW);
  assign rd_kind   = hit_read || hit_stat;
  assign bus_kind  = hit_cmd || hit_param || hit_data || rd_kind;
  assign chip_sel  = ctrl_q[3:2];

  // access handshake
  assign need_bus  = reg_valid && reg_write && bus_kind && (chip_sel != 2'b00);
  assign eng_go    = need_bus && !eng_busy;
  assign reg_ready = reg_valid && (!need_bus || eng_done);
  assign commit    = reg_valid && reg_write && reg_ready;
  assign soft_clr  = commit && hit_sys && reg_wdata[1];
  assign tick      = commit && (hit_data || rd_kind);

  assign eng_op = hit_data ? OP_WR2 : (rd_kind ? OP_RD : OP_WR1);
  assign eng_dc = !(hit_cmd || hit_stat);
  assign eng_cs = rd_kind ? (chip_sel[0] ? 2'b01 : 2'b10) : chip_sel;

  pdb_beat_engine u_eng (
    .clk(clk), .rst_n(rst_n), .go_i(eng_go), .op_i(eng_op), .dc_i(eng_dc),
    .cs_i(eng_cs), .wdata_i(reg_wdata), .busy_o(eng_busy), .done_o(eng_done),
    .rword_o(eng_rword), .pb_cs(pb_cs_o), .pb_dc(pb_dc_o), .pb_wr(pb_wr_o),
    .pb_rd(pb_rd_o), .pb_wdata(pb_wdata_o), .pb_rdata(pb_rdata_i),
    .pb_ready(pb_ready_i)
  );

  // per-chip timing banks
  logic [RW-1:0]    bank_rd  [NCHIP];
  logic [1:0]       bank_cs  [NCHIP];
  logic [NCHIP-1:0] bank_hit;

  for (genvar g = 0; g < NCHIP; g++) begin : g_bank
    localparam logic [REG_AW-1:0] BASE = REG_AW'(BANK_BASE + g * BANK_REGS);
    logic [REG_AW-1:0] off;
    assign off         = reg_addr - BASE;
    assign bank_hit[g] = (off < REG_AW'(BANK_REGS));
    pdb_timing_bank u_bank (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_clr),
      .we_i(commit && bank_hit[g]), .sel_i(off[2:0]), .wdata_i(reg_wdata),
      .rdata_o(bank_rd[g]), .csel_o(bank_cs[g])
    );
  end

  assign clash = |(bank_cs[0] & bank_cs[1]);

  pdb_frame_ctl #(.PIX_W(PIX_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr_i(soft_clr),
    .cnt_we_i(commit && hit_pix), .cnt_wdata_i(reg_wdata[PIX_W-1:0]),
    .tick_i(tick), .trig_i(commit && hit_ctrl && reg_wdata[4]),
    .en_i(reg_wdata[0]), .byp_i(reg_wdata[1]), .mode_ok_i(ctl_mode_i),
    .clash_i(clash), .count_o(pix_count), .busy_o(busy),
    .fetch_start_o(fetch_start_o), .frame_done_o(frame_done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      sys_q  <= '0;
      skip_q <= '0;
      vsw_q  <= '0;
      hsw_q  <= '0;
      rx_q   <= '0;
    end else if (soft_clr) begin
      ctrl_q <= CTRL_RST;
      sys_q  <= reg_wdata[4:0] & SYS_MASK;
      skip_q <= '0;
      vsw_q  <= '0;
      hsw_q  <= '0;
    end else if (commit) begin
      if (hit_sys)  sys_q  <= reg_wdata[4:0] & SYS_MASK;
      if (hit_ctrl) ctrl_q <= reg_wdata[3:0];
      if (hit_skip) skip_q <= reg_wdata[LINE_W-1:0];
      if (hit_vsw)  vsw_q  <= reg_wdata[SYNC_W-1:0];
      if (hit_hsw)  hsw_q  <= reg_wdata[SYNC_W-1:0];
      if (eng_done && rd_kind) rx_q <= eng_rword;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_sys)       reg_rdata = RW'(sys_q);
    else if (reg_addr == A_SYSSTAT) reg_rdata = RW'({busy, 7'b0, 1'b1});
    else if (hit_ctrl) reg_rdata = RW'(ctrl_q);
    else if (hit_pix)  reg_rdata = RW'(pix_count);
    else if (hit_skip) reg_rdata = RW'(skip_q);
    else if (rd_kind)  reg_rdata = RW'(rx_q);
    else if (hit_vsw)  reg_rdata = RW'(vsw_q);
    else if (hit_hsw)  reg_rdata = RW'(hsw_q);
    else begin
      for (int i = 0; i < NCHIP; i++)
        if (bank_hit[i]) reg_rdata = bank_rd[i];
    end
  end

  p_start_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start_o |-> (ctrl_q[0] && !ctrl_q[1]));
  p_ready_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ready && need_bus) |-> (pb_wr_o || pb_rd_o));
endmodule

// File: tb/pdisp_bridge_test.sv
module pdisp_bridge_test;
  import pdb_pkg::*;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0, reg_ready;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ctl_mode = 1'b0;
  logic [1:0] pb_cs, pb_ready;
  logic pb_dc, pb_wr, pb_rd, fetch_start, frame_done;
  logic [15:0] pb_wdata, pb_rdata;

  int nchk = 0, nerr = 0;
  int lat [2];
  int ccnt [2];
  logic [19:0] log_v [64];
  int nlog = 0, fs_cnt = 0, fd_cnt = 0, fd_run = 0, fd_max = 0;

  always #(PER/2) clk = ~clk;

  pdisp_bridge uut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctl_mode_i(ctl_mode), .pb_cs_o(pb_cs),
    .pb_dc_o(pb_dc), .pb_wr_o(pb_wr), .pb_rd_o(pb_rd), .pb_wdata_o(pb_wdata),
    .pb_rdata_i(pb_rdata), .pb_ready_i(pb_ready),
    .fetch_start_o(fetch_start), .frame_done_o(frame_done)
  );

  // chip models: ready after lat cycles of active strobe
  assign pb_rdata = !pb_rd ? 16'h0 :
                    (pb_cs == 2'b01) ? (pb_dc ? 16'h1234 : 16'h12CB) :
                                       (pb_dc ? 16'h5678 : 16'h5687);

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n || !(pb_cs[i] && (pb_wr || pb_rd))) begin
        ccnt[i] <= 0;
        pb_ready[i] <= 1'b0;
      end else begin
        ccnt[i] <= ccnt[i] + 1;
        pb_ready[i] <= (ccnt[i] + 1 >= lat[i]);
      end
    end
    if (rst_n && (pb_wr || pb_rd) && (&(pb_ready | ~pb_cs))) begin
      log_v[nlog % 64] <= {pb_cs, pb_dc, pb_rd, pb_rd ? pb_rdata : pb_wdata};
      nlog <= nlog + 1;
    end
    if (fetch_start) fs_cnt <= fs_cnt + 1;
    if (frame_done) begin
      fd_cnt <= fd_cnt + 1;
      fd_run <= fd_run + 1;
      if (fd_run + 1 > fd_max) fd_max <= fd_run + 1;
    end else fd_run <= 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_wdata = d;
    cyc = 0;
    forever begin
      #(PER/2 - 1);
      cyc++;
      if (reg_ready) begin
        rd = reg_rdata;
        @(posedge clk);
        break;
      end
      @(posedge clk);
    end
    #1 reg_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] r; int c;
    access(1'b1, a, d, r, c);
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
    int c;
    access(1'b0, a, 32'h0, v, c);
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  // {addr, write data, expected read-back}
  localparam logic [68:0] VEC [12] = '{
    {5'd2,  32'hFFFF_FFFF, 32'h0000_000F},
    {5'd10, 32'hFFFF_FFFF, 32'h003F_1FFF},
    {5'd11, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
    {5'd12, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
    {5'd14, 32'hFFFF_FFFF, 32'h0F1F_0F1F},
    {5'd16, 32'h1234_5678, 32'h0034_1678},
    {5'd17, 32'hC000_0001, 32'h0000_0001},
    {5'd4,  32'hFFFF_FFFF, 32'h0000_07FF},
    {5'd22, 32'hABCD_1234, 32'h0000_1234},
    {5'd23, 32'hFFFF_0FF0, 32'h0000_0FF0},
    {5'd0,  32'hFFFF_FFFD, 32'h0000_0019},
    {5'd3,  32'hDEAD_BEEF, 32'hDEAD_BEEF}
  };

  initial begin
    #(PER * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int c, b;
    lat[0] = 3; lat[1] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_reg(A_CTRL, v);    check("R1 ctrl", v, 32'h2);
    rd_reg(5'd10, v);     check("R1 cfg0", v, 32'h0031_0000);
    rd_reg(5'd16, v);     check("R1 cfg1", v, 32'h0031_0000);
    rd_reg(A_SYSSTAT, v); check("R1 sysstat", v, 32'h1);
    rd_reg(A_PIXCNT, v);  check("R1 pixcnt", v, 32'h0);
    rd_reg(5'd17, v);     check("R1 onoff1", v, 32'h0);
    check("R1 pulses", {30'b0, fetch_start, frame_done}, 32'h0);

    // R2 / R12 / R13 write masks
    for (int i = 0; i < 12; i++) begin
      wr_reg(VEC[i][68:64], VEC[i][63:32]);
      rd_reg(VEC[i][68:64], v);
      if (VEC[i][68:64] == A_CTRL) check("R2 ctrl mask", v, VEC[i][31:0]);
      else if (VEC[i][68:64] == A_SYSCFG) check("R13 syscfg mask", v, VEC[i][31:0]);
      else check("R12 field mask", v, VEC[i][31:0]);
    end

    // R13 soft reset
    wr_reg(A_SYSCFG, 32'h2);
    rd_reg(A_CTRL, v);   check("R13 ctrl", v, 32'h2);
    rd_reg(5'd10, v);    check("R13 cfg0", v, 32'h0031_0000);
    rd_reg(A_PIXCNT, v); check("R13 pixcnt", v, 32'h0);
    rd_reg(A_SYSCFG, v); check("R13 syscfg", v, 32'h0);
    rd_reg(A_VSW, v);    check("R13 vsw", v, 32'h0);

    // R3 command beat on chip 0 with 3-cycle latency
    wr_reg(A_CTRL, 32'h4);
    b = nlog;
    access(1'b1, A_CMD, 32'hABCD_1234, v, c);
    settle();
    check("R3 stall cycles", c, 5);
    check("R3 beat count", nlog - b, 1);
    check("R3 beat", {12'b0, log_v[b % 64]}, {12'b0, 2'b01, 1'b0, 1'b0, 16'h1234});

    // R4 parameter beat
    b = nlog;
    wr_reg(A_PARAM, 32'h0000_BEEF);
    settle();
    check("R4 beat", {12'b0, log_v[b % 64]}, {12'b0, 2'b01, 1'b1, 1'b0, 16'hBEEF});

    // R5 data write split to both chips
    wr_reg(A_CTRL, 32'hC);
    b = nlog;
    wr_reg(A_DATA, 32'h5555_AAAA);
    settle();
    check("R5 beat count", nlog - b, 2);
    check("R5 low half", {12'b0, log_v[b % 64]}, {12'b0, 2'b11, 1'b1, 1'b0, 16'hAAAA});
    check("R5 high half", {12'b0, log_v[(b + 1) % 64]}, {12'b0, 2'b11, 1'b1, 1'b0, 16'h5555});

    // R6 read port prefers chip 0, status port on chip 1
    b = nlog;
    wr_reg(A_READ, 32'h0);
    settle();
    check("R6 read beat", {12'b0, log_v[b % 64]}, {12'b0, 2'b01, 1'b1, 1'b1, 16'h1234});
    rd_reg(A_READ, v); check("R6 rx buffer", v, 32'h1234);
    wr_reg(A_CTRL, 32'h8);
    b = nlog;
    wr_reg(A_STAT, 32'h0);
    settle();
    check("R6 status beat", {12'b0, log_v[b % 64]}, {12'b0, 2'b10, 1'b0, 1'b1, 16'h5687});
    rd_reg(A_STAT, v); check("R6 status buffer", v, 32'h5687);

    // R7 no chip selected
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_PIXCNT, 32'h2);
    b = nlog;
    access(1'b1, A_CMD, 32'h1111, v, c);
    check("R7 immediate", c, 1);
    access(1'b1, A_DATA, 32'h2222, v, c);
    settle();
    check("R7 no beats", nlog - b, 0);
    rd_reg(A_PIXCNT, v); check("R7 count moved", v, 32'h1);

    // R9 / R11 frame run
    ctl_mode = 1'b1;
    wr_reg(A_PIXCNT, 32'h3);
    wr_reg(A_CTRL, 32'h11);
    settle();
    check("R9 fetch pulse", fs_cnt, 1);
    rd_reg(A_SYSSTAT, v); check("R9 busy", v, 32'h101);
    wr_reg(A_CTRL, 32'h11);
    settle();
    check("R10 busy ignore", fs_cnt, 1);
    wr_reg(A_DATA, 32'h0);
    wr_reg(A_DATA, 32'h0);
    rd_reg(A_SYSSTAT, v); check("R11 still busy", v, 32'h101);
    check("R11 no early done", fd_cnt, 0);
    wr_reg(A_DATA, 32'h0);
    settle();
    rd_reg(A_SYSSTAT, v); check("R11 busy clear", v, 32'h1);
    check("R11 done pulse", fd_cnt, 1);
    check("R11 pulse width", fd_max, 1);
    wr_reg(A_DATA, 32'h0);
    settle();
    rd_reg(A_PIXCNT, v); check("R8 stays zero", v, 32'h0);
    check("R8 no extra done", fd_cnt, 1);

    // R10 rejected starts
    wr_reg(A_PIXCNT, 32'h5);
    wr_reg(A_CTRL, 32'h10);
    wr_reg(A_CTRL, 32'h13);
    ctl_mode = 1'b0;
    wr_reg(A_CTRL, 32'h11);
    ctl_mode = 1'b1;
    wr_reg(5'd10, 32'h4);
    wr_reg(5'd16, 32'h4);
    wr_reg(A_CTRL, 32'h11);
    settle();
    check("R10 rejected", fs_cnt, 1);
    rd_reg(A_SYSSTAT, v); check("R10 not busy", v, 32'h1);
    wr_reg(5'd16, 32'h8);
    wr_reg(A_CTRL, 32'h11);
    settle();
    check("R9 start no clash", fs_cnt, 2);

    // R13 soft reset clears busy silently
    wr_reg(A_SYSCFG, 32'h2);
    settle();
    rd_reg(A_SYSSTAT, v); check("R13 busy cleared", v, 32'h1);
    check("R13 no done", fd_cnt, 1);

    finish_run();
  end
endmodule